// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for a synchronous memory that serves four-beat bursts. On a load cycle, when the memory is selected, it takes a complete external address. Each later advance cycle moves the two lowest address bits to the next beat. All higher bits keep the loaded value. A static order input picks the beat order. One order is a wrapping up-count. The other is interleaved: it forms the low bits as the start offset XOR the beat number.

A load cycle seen while the memory is not selected ends the burst. An advance seen while no burst is running changes nothing. While the suspend input is high, the block ignores every other input and all of its state stays as it was. The outputs are the current address and a flag that shows a burst is running. Both come from registers, so every effect appears one clock edge after the cycle that causes it.

Top module: `burst_seq`

## Requirements
- R1: After reset, `mem_addr` is zero and `burst_on` is low.
- R2: When `suspend`=0, `advance`=0 and `select`=1 at an edge, `mem_addr` equals `ext_addr` after that edge and `burst_on` is 1.
- R3: When `order_xor`=0, each advance during a burst adds one modulo 4 to `mem_addr[1:0]`. For example, start 01 gives 01, 10, 11, 00.
- R4: When `order_xor`=1, `mem_addr[1:0]` is the start offset XOR the beat count. Starts 00, 01, 10 and 11 give 00-01-10-11, 01-00-11-10, 10-11-00-01 and 11-10-01-00.
- R5: After the fourth beat, the next advance returns `mem_addr[1:0]` to the start offset, and counting carries on from there.
- R6: During advance cycles, `mem_addr[AW-1:2]` keeps its loaded value and `ext_addr` and `select` have no effect.
- R7: When `suspend`=0, `advance`=0 and `select`=0 at an edge, `burst_on` falls and `mem_addr` keeps its value.
- R8: An advance while `burst_on` is low leaves `mem_addr` unchanged and keeps `burst_on` low.
- R9: While `suspend`=1, `mem_addr` and `burst_on` hold whatever `advance`, `select` and `ext_addr` do. When `suspend` returns to 0, the burst resumes from the beat where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| suspend | input | 1 | 1 = ignore this edge and hold all state |
| advance | input | 1 | 1 = step the burst, 0 = load or stop |
| select | input | 1 | Memory selected; used on load cycles only |
| order_xor | input | 1 | Static order: 1 = interleaved, 0 = linear |
| ext_addr | input | AW | External address taken on a load |
| mem_addr | output | AW | Current memory address |
| burst_on | output | 1 | A burst is running |

## Verification
Both outputs are registered, so every result is due exactly one rising edge after the cycle that drives its stimulus. The bench sets inputs just after a falling edge and reads the outputs at the next falling edge. In that way, each check covers exactly one rising edge. For suspend, stop and idle-advance cycles, the bench checks that the outputs still match the value from the previous check. When suspend is released, the bench checks that the next advance continues from the beat where the burst stopped.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   typedef enum logic [2:0] {
      OP_HOLD,
      OP_LOAD,
      OP_STOP,
      OP_STEP,
      OP_NONE
   } seq_op_e;

   localparam int ORDER_BY_PIN = 0;
   localparam int ORDER_LINEAR = 1;
   localparam int ORDER_XOR    = 2;

endpackage

// File: rtl/burst_seq_dec.sv
module burst_seq_dec
   import burst_seq_pkg::*;
(
   input  logic    suspend,
   input  logic    advance,
   input  logic    select,
   input  logic    running,
   output seq_op_e op
);

   always_comb begin
      if (suspend)
         op = OP_HOLD;
      else if (!advance)
         op = select ? OP_LOAD : OP_STOP;
      else
         op = running ? OP_STEP : OP_NONE;
   end

endmodule

// File: rtl/burst_seq_state.sv
module burst_seq_state
   import burst_seq_pkg::*;
#(
   parameter int AW = 20,
   parameter int LW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  seq_op_e       op,
   input  logic [AW-1:0] ext_addr,
   output logic [AW-1:0] base,
   output logic [LW-1:0] beat,
   output logic          running
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base    <= '0;
         beat    <= '0;
         running <= 1'b0;
      end else begin
         unique case (op)
            OP_LOAD: begin
               base    <= ext_addr;
               beat    <= '0;
               running <= 1'b1;
            end
            OP_STOP: running <= 1'b0;
            OP_STEP: beat    <= beat + 1'b1;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/burst_seq_map.sv
module burst_seq_map
   import burst_seq_pkg::*;
#(
   parameter int AW        = 20,
   parameter int LW        = 2,
   parameter int ORDER_SEL = ORDER_BY_PIN
) (
   input  logic [AW-1:0] base,
   input  logic [LW-1:0] beat,
   input  logic          order_xor,
   output logic [AW-1:0] addr
);

   logic [LW-1:0] lin_low;
   logic [LW-1:0] xor_low;
   logic [LW-1:0] low;

   assign lin_low = base[LW-1:0] + beat;
   assign xor_low = base[LW-1:0] ^ beat;

   generate
      if (ORDER_SEL == ORDER_LINEAR) begin : g_lin
         logic unused_order;
         assign unused_order = order_xor;
         assign low = lin_low;
      end else if (ORDER_SEL == ORDER_XOR) begin : g_xor
         logic unused_order;
         assign unused_order = order_xor;
         assign low = xor_low;
      end else begin : g_pin
         assign low = order_xor ? xor_low : lin_low;
      end
   endgenerate

   assign addr = {base[AW-1:LW], low};

endmodule

// File: rtl/burst_seq.sv
module burst_seq
   import burst_seq_pkg::*;
#(
   parameter int AW        = 20,
   parameter int LW        = 2,
   parameter int ORDER_SEL = ORDER_BY_PIN
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          suspend,
   input  logic          advance,
   input  logic          select,
   input  logic          order_xor,
   input  logic [AW-1:0] ext_addr,
   output logic [AW-1:0] mem_addr,
   output logic          burst_on
);

   generate
      if (LW < 1) begin : g_bad_lw
         $error("burst_seq: LW must be at least 1");
      end
      if (AW <= LW) begin : g_bad_aw
         $error("burst_seq: AW must exceed LW");
      end
      if (ORDER_SEL < ORDER_BY_PIN || ORDER_SEL > ORDER_XOR) begin : g_bad_ord
         $error("burst_seq: ORDER_SEL out of range");
      end
   endgenerate

   seq_op_e       op;
   logic [AW-1:0] base;
   logic [LW-1:0] beat;

   burst_seq_dec u_dec (
      .suspend (suspend),
      .advance (advance),
      .select  (select),
      .running (burst_on),
      .op      (op)
   );

   burst_seq_state #(.AW(AW), .LW(LW)) u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .ext_addr (ext_addr),
      .base     (base),
      .beat     (beat),
      .running  (burst_on)
   );

   burst_seq_map #(.AW(AW), .LW(LW), .ORDER_SEL(ORDER_SEL)) u_map (
      .base      (base),
      .beat      (beat),
      .order_xor (order_xor),
      .addr      (mem_addr)
   );

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk
   import burst_seq_pkg::*;
#(
   parameter int AW        = 20,
   parameter int LW        = 2,
   parameter int ORDER_SEL = ORDER_BY_PIN
) (
   input logic          clk,
   input logic          rst_n,
   input logic          suspend,
   input logic          advance,
   input logic          select,
   input logic          order_xor,
   input logic [AW-1:0] ext_addr,
   input logic [AW-1:0] mem_addr,
   input logic          burst_on
);

   logic lin_mode;
   assign lin_mode = (ORDER_SEL == ORDER_LINEAR) ||
                     (ORDER_SEL == ORDER_BY_PIN && !order_xor);

   a_r2_load_takes_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (!suspend && !advance && select) |=> (mem_addr == $past(ext_addr) && burst_on));

   a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!suspend && advance && burst_on && lin_mode) |=>
      (!$stable(order_xor) ||
       mem_addr[LW-1:0] == LW'($past(mem_addr[LW-1:0]) + 1'b1)));

   a_r6_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (!suspend && advance && burst_on) |=> $stable(mem_addr[AW-1:LW]));

   a_r7_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!suspend && !advance && !select) |=> !burst_on);

   a_r8_idle_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (!suspend && advance && !burst_on) |=>
      (!burst_on && ($stable(mem_addr) || !$stable(order_xor))));

   a_r9_suspend_hold: assert property (@(posedge clk) disable iff (!rst_n)
      suspend |=> ($stable(burst_on) && ($stable(mem_addr) || !$stable(order_xor))));

endmodule

bind burst_seq burst_seq_chk #(.AW(AW), .LW(LW), .ORDER_SEL(ORDER_SEL)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .suspend   (suspend),
   .advance   (advance),
   .select    (select),
   .order_xor (order_xor),
   .ext_addr  (ext_addr),
   .mem_addr  (mem_addr),
   .burst_on  (burst_on)
);

// File: tb/sim_burst_seq.sv
module sim_burst_seq;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 20;

   // {order_xor, start, beat0..beat4 expected low bits}
   localparam logic [12:0] VEC [8] = '{
      {1'b0, 2'd0, 10'b00_01_10_11_00},
      {1'b0, 2'd1, 10'b01_10_11_00_01},
      {1'b0, 2'd2, 10'b10_11_00_01_10},
      {1'b0, 2'd3, 10'b11_00_01_10_11},
      {1'b1, 2'd0, 10'b00_01_10_11_00},
      {1'b1, 2'd1, 10'b01_00_11_10_01},
      {1'b1, 2'd2, 10'b10_11_00_01_10},
      {1'b1, 2'd3, 10'b11_10_01_00_11}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          suspend = 1'b0;
   logic          advance = 1'b1;
   logic          select = 1'b0;
   logic          order_xor = 1'b0;
   logic [AW-1:0] ext_addr = '0;
   logic [AW-1:0] mem_addr;
   logic          burst_on;

   int n_total = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_seq #(.AW(AW)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .suspend   (suspend),
      .advance   (advance),
      .select    (select),
      .order_xor (order_xor),
      .ext_addr  (ext_addr),
      .mem_addr  (mem_addr),
      .burst_on  (burst_on)
   );

   task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_total++;
      n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      logic [AW-1:0] hold_a;
      logic [AW-3:0] up;

      // R1: reset state, then an advance with no burst running
      @(negedge clk);
      chk("R1 addr", mem_addr, '0);
      chk("R1 burst_on", {19'd0, burst_on}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 idle after reset", mem_addr, '0);

      // table walk: both orders, all starts, wrap on fifth beat
      for (int i = 0; i < 8; i++) begin
         order_xor = VEC[i][12];
         up        = (AW-2)'(i * 4099 + 17);
         ext_addr  = {up, VEC[i][11:10]};
         advance   = 1'b0;
         select    = 1'b1;
         @(negedge clk);
         chk("R2 load", mem_addr, {up, VEC[i][9:8]});
         chk("R2 burst_on", {19'd0, burst_on}, 20'd1);
         for (int k = 1; k <= 4; k++) begin
            advance  = 1'b1;
            select   = k[0];
            ext_addr = ~ext_addr;
            @(negedge clk);
            if (order_xor)
               chk(k == 4 ? "R5 R6 R4 wrap" : "R4 R6 xor beat", mem_addr, {up, VEC[i][9-2*k -: 2]});
            else
               chk(k == 4 ? "R5 R6 R3 wrap" : "R3 R6 linear beat", mem_addr, {up, VEC[i][9-2*k -: 2]});
         end
         // R5: counting carries on after the wrap
         @(negedge clk);
         chk("R5 after wrap", mem_addr, {up, VEC[i][7:6]});
      end

      // R9: suspend holds a running burst
      order_xor = 1'b0;
      ext_addr  = 20'hABCD2;
      advance   = 1'b0;
      select    = 1'b1;
      @(negedge clk);
      hold_a = mem_addr;
      chk("R2 directed load", mem_addr, 20'hABCD2);
      suspend  = 1'b1;
      ext_addr = 20'h12345;
      @(negedge clk);
      chk("R9 suspend load ignored", mem_addr, hold_a);
      advance = 1'b1;
      @(negedge clk);
      chk("R9 suspend advance ignored", mem_addr, hold_a);
      select  = 1'b0;
      advance = 1'b0;
      @(negedge clk);
      chk("R9 suspend stop ignored", {19'd0, burst_on}, 20'd1);
      suspend = 1'b0;
      advance = 1'b1;
      @(negedge clk);
      chk("R9 resume next beat", mem_addr, 20'hABCD3);

      // R7: stop keeps address, clears flag
      advance = 1'b0;
      select  = 1'b0;
      @(negedge clk);
      chk("R7 flag low", {19'd0, burst_on}, '0);
      chk("R7 addr held", mem_addr, 20'hABCD3);

      // R8: advance while idle
      advance = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R8 idle addr", mem_addr, 20'hABCD3);
      chk("R8 idle flag", {19'd0, burst_on}, '0);

      // R9: suspended load while idle does nothing
      suspend  = 1'b1;
      advance  = 1'b0;
      select   = 1'b1;
      ext_addr = 20'h00F01;
      @(negedge clk);
      chk("R9 idle suspend flag", {19'd0, burst_on}, '0);
      chk("R9 idle suspend addr", mem_addr, 20'hABCD3);

      // R2: a new load restarts a running burst
      suspend = 1'b0;
      @(negedge clk);
      advance = 1'b1;
      @(negedge clk);
      ext_addr = 20'h55550;
      advance  = 1'b0;
      @(negedge clk);
      chk("R2 reload mid burst", mem_addr, 20'h55550);

      // R1: reset during a burst
      rst_n = 1'b0;
      #1;
      chk("R1 reset addr", mem_addr, '0);
      chk("R1 reset flag", {19'd0, burst_on}, '0);

      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

endmodule